// File: doc/BRIEF.md
# Two-Memory Paged Access Arbiter

This block sits in front of two on-chip data memories, called X and Y, and decides which bus may touch each of them in every clock cycle. Each memory is cut into pages, and each page is a separate storage bank with its own port. Three requesters compete for the pages. The first is a system requester that is already physically addressed and may reach either memory. The second is a pair of dedicated DSP buses, one wired to X memory only and one wired to Y memory only. The third is a local CPU bus that may reach either memory, but only when the current privilege mode permits it.

Requests that land on different banks are all granted in the same cycle. When two or more requests land on the same bank, a fixed priority chooses the winner. The losers see ready stay low and keep their request up until a later cycle grants them. A local-bus request that the mode check forbids ends at once with an error pulse and changes no memory.

The handshake on every bus works the same way. Ready is combinational in the request cycle. A write lands at the clock edge that ends the granted cycle. Read data appears on the requester's read-data port in the following cycle.

Top module: `xyMemArb`

## Requirements
- R1: A system request (iReq) is granted (iReady=1) in the same cycle it is raised, whatever the other buses do.
- R2: On a bank of X memory, a system request beats the X DSP bus, and the X DSP bus beats the local bus; the local bus gets lReady=0 while xReq targets the same X page.
- R3: On a bank of Y memory, a system request beats the Y DSP bus, and the Y DSP bus beats the local bus.
- R4: Requests to different banks are granted together in one cycle, so an X DSP request and a Y DSP request are both granted unless the system bus holds the same page.
- R5: A losing requester sees ready low in every cycle the page stays taken, and it is granted in the first cycle its page is free.
- R6: The local bus is permitted when modePriv=1 and lUserRegion=0, or when modePriv=0, modeDsp=1 and lUserRegion=1; every other combination is refused.
- R7: A refused local request drives lErr=1 and lReady=0 in that cycle and leaves memory unchanged.
- R8: On the system and local buses, address bit AW selects the memory (0 = X, 1 = Y); on every bus the next lower log2(NPAGE) bits select the page and the rest give the word offset. A write takes effect at the edge that ends the grant cycle, and read data shows on the requester's rdata port in the cycle after the grant.
- R9: While rstN is low no request is granted and lErr stays low; after reset every rdata port reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modePriv | input | 1 | Privileged mode flag |
| modeDsp | input | 1 | DSP-enabled flag for user mode |
| iReq | input | 1 | System bus request |
| iWe | input | 1 | System bus write enable |
| iAddr | input | AW+1 | System bus address, memory select in top bit |
| iWdata | input | DW | System bus write data |
| iReady | output | 1 | System bus grant |
| iRdata | output | DW | System bus read data, cycle after grant |
| xReq | input | 1 | X DSP bus request |
| xWe | input | 1 | X DSP bus write enable |
| xAddr | input | AW | X DSP bus word address in X memory |
| xWdata | input | DW | X DSP bus write data |
| xReady | output | 1 | X DSP bus grant |
| xRdata | output | DW | X DSP bus read data |
| yReq | input | 1 | Y DSP bus request |
| yWe | input | 1 | Y DSP bus write enable |
| yAddr | input | AW | Y DSP bus word address in Y memory |
| yWdata | input | DW | Y DSP bus write data |
| yReady | output | 1 | Y DSP bus grant |
| yRdata | output | DW | Y DSP bus read data |
| lReq | input | 1 | Local bus request |
| lWe | input | 1 | Local bus write enable |
| lAddr | input | AW+1 | Local bus address, memory select in top bit |
| lUserRegion | input | 1 | 1 = access issued from user region, 0 = privileged region |
| lWdata | input | DW | Local bus write data |
| lReady | output | 1 | Local bus grant |
| lErr | output | 1 | Local bus refusal pulse |
| lRdata | output | DW | Local bus read data |

## Verification
Grants and the refusal pulse are combinational, so the bench checks them one time unit after it drives the inputs at the falling edge, in that same cycle. Read data passes through one register behind the grant, so it is checked one time unit after the next rising edge. The expected word is taken from a bench model of both memories as it stood before that edge's writes, and the model takes a write only when the bench's own rules grant it. A sweep over every combination of requests, targets, pages and modes covers the priority and permission rules. Directed sequences hold a page busy for several cycles, and they try a refused write followed by a read of the same word.

// File: rtl/xyMemArbPkg.sv
package xyMemArbPkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_I    = 2'd1,
    SRC_DSP  = 2'd2,
    SRC_L    = 2'd3
  } srcSel_e;

  // per-bank command from control to datapath
  typedef struct packed {
    logic    en;
    logic    we;
    srcSel_e src;
  } bankStrobe_t;
endpackage

// File: rtl/xyMemArbCtrl.sv
module xyMemArbCtrl
  import xyMemArbPkg::*;
#(
  parameter int AW    = 6,
  parameter int NPAGE = 2
) (
  input  logic          rstN,
  input  logic          modePriv,
  input  logic          modeDsp,
  input  logic          iReq,
  input  logic          iWe,
  input  logic [AW:0]   iAddr,
  input  logic          xReq,
  input  logic          xWe,
  input  logic [AW-1:0] xAddr,
  input  logic          yReq,
  input  logic          yWe,
  input  logic [AW-1:0] yAddr,
  input  logic          lReq,
  input  logic          lWe,
  input  logic [AW:0]   lAddr,
  input  logic          lUserRegion,
  output bankStrobe_t   strobe [2*NPAGE],
  output logic          iReady,
  output logic          xReady,
  output logic          yReady,
  output logic          lReady,
  output logic          lErr
);
  localparam int PB    = $clog2(NPAGE);
  localparam int NBANK = 2 * NPAGE;
  localparam int BW    = PB + 1;

  logic lOk;
  logic [NBANK-1:0] iHit, dHit, lHit, dWin, lWin;

  // mode permission for direct local access (R6)
  assign lOk = modePriv ? ~lUserRegion : (modeDsp & lUserRegion);

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      assign iHit[b] = rstN && iReq && (iAddr[AW -: BW] == BW'(b));
      assign dHit[b] = rstN && ((xReq && ({1'b0, xAddr[AW-1 -: PB]} == BW'(b))) ||
                                (yReq && ({1'b1, yAddr[AW-1 -: PB]} == BW'(b))));
      assign lHit[b] = rstN && lReq && lOk && (lAddr[AW -: BW] == BW'(b));
      assign dWin[b] = dHit[b] & ~iHit[b];
      assign lWin[b] = lHit[b] & ~iHit[b] & ~dHit[b];

      always_comb begin
        strobe[b].en  = iHit[b] | dHit[b] | lHit[b];
        strobe[b].src = SRC_NONE;
        strobe[b].we  = 1'b0;
        if (iHit[b]) begin
          strobe[b].src = SRC_I;
          strobe[b].we  = iWe;
        end else if (dHit[b]) begin
          strobe[b].src = SRC_DSP;
          strobe[b].we  = (b < NPAGE) ? xWe : yWe;
        end else if (lHit[b]) begin
          strobe[b].src = SRC_L;
          strobe[b].we  = lWe;
        end
      end
    end
  endgenerate

  assign iReady = |iHit;
  assign xReady = |dWin[NPAGE-1:0];
  assign yReady = |dWin[NBANK-1:NPAGE];
  assign lReady = |lWin;
  assign lErr   = rstN && lReq && !lOk;
endmodule

// File: rtl/xyMemArbDatapath.sv
module xyMemArbDatapath
  import xyMemArbPkg::*;
#(
  parameter int AW    = 6,
  parameter int NPAGE = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  bankStrobe_t   strobe [2*NPAGE],
  input  logic          iReady,
  input  logic          xReady,
  input  logic          yReady,
  input  logic          lReady,
  input  logic [AW:0]   iAddr,
  input  logic [DW-1:0] iWdata,
  input  logic [AW-1:0] xAddr,
  input  logic [DW-1:0] xWdata,
  input  logic [AW-1:0] yAddr,
  input  logic [DW-1:0] yWdata,
  input  logic [AW:0]   lAddr,
  input  logic [DW-1:0] lWdata,
  output logic [DW-1:0] iRdata,
  output logic [DW-1:0] xRdata,
  output logic [DW-1:0] yRdata,
  output logic [DW-1:0] lRdata
);
  localparam int PB    = $clog2(NPAGE);
  localparam int NBANK = 2 * NPAGE;
  localparam int BW    = PB + 1;
  localparam int OW    = AW - PB;
  localparam int DEPTH = 1 << OW;

  logic [DW-1:0] bankQ [NBANK];
  logic [BW-1:0] iRet, xRet, yRet, lRet;

  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      logic [DW-1:0] store [DEPTH];
      logic [OW-1:0] off;
      logic [DW-1:0] wd;

      always_comb begin
        off = '0;
        wd  = '0;
        case (strobe[b].src)
          SRC_I: begin
            off = iAddr[OW-1:0];
            wd  = iWdata;
          end
          SRC_DSP: begin
            off = (b < NPAGE) ? xAddr[OW-1:0] : yAddr[OW-1:0];
            wd  = (b < NPAGE) ? xWdata : yWdata;
          end
          SRC_L: begin
            off = lAddr[OW-1:0];
            wd  = lWdata;
          end
          default: ;
        endcase
      end

      always_ff @(posedge clk) begin
        if (strobe[b].en && strobe[b].we) store[off] <= wd;
      end

      always_ff @(posedge clk) begin
        if (!rstN) bankQ[b] <= '0;
        else if (strobe[b].en && !strobe[b].we) bankQ[b] <= store[off];
      end
    end
  endgenerate

  // remember which bank each requester was granted, for read return
  always_ff @(posedge clk) begin
    if (!rstN) begin
      iRet <= '0;
      xRet <= '0;
      yRet <= BW'(NPAGE);
      lRet <= '0;
    end else begin
      if (iReady) iRet <= iAddr[AW -: BW];
      if (xReady) xRet <= {1'b0, xAddr[AW-1 -: PB]};
      if (yReady) yRet <= {1'b1, yAddr[AW-1 -: PB]};
      if (lReady) lRet <= lAddr[AW -: BW];
    end
  end

  assign iRdata = bankQ[iRet];
  assign xRdata = bankQ[xRet];
  assign yRdata = bankQ[yRet];
  assign lRdata = bankQ[lRet];
endmodule

// File: rtl/xyMemArb.sv
module xyMemArb
  import xyMemArbPkg::*;
#(
  parameter int AW    = 6,
  parameter int NPAGE = 2,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          modePriv,
  input  logic          modeDsp,
  input  logic          iReq,
  input  logic          iWe,
  input  logic [AW:0]   iAddr,
  input  logic [DW-1:0] iWdata,
  output logic          iReady,
  output logic [DW-1:0] iRdata,
  input  logic          xReq,
  input  logic          xWe,
  input  logic [AW-1:0] xAddr,
  input  logic [DW-1:0] xWdata,
  output logic          xReady,
  output logic [DW-1:0] xRdata,
  input  logic          yReq,
  input  logic          yWe,
  input  logic [AW-1:0] yAddr,
  input  logic [DW-1:0] yWdata,
  output logic          yReady,
  output logic [DW-1:0] yRdata,
  input  logic          lReq,
  input  logic          lWe,
  input  logic [AW:0]   lAddr,
  input  logic          lUserRegion,
  input  logic [DW-1:0] lWdata,
  output logic          lReady,
  output logic          lErr,
  output logic [DW-1:0] lRdata
);
  bankStrobe_t strobe [2*NPAGE];

  xyMemArbCtrl #(.AW(AW), .NPAGE(NPAGE)) u_ctrl (
    .rstN(rstN), .modePriv(modePriv), .modeDsp(modeDsp),
    .iReq(iReq), .iWe(iWe), .iAddr(iAddr),
    .xReq(xReq), .xWe(xWe), .xAddr(xAddr),
    .yReq(yReq), .yWe(yWe), .yAddr(yAddr),
    .lReq(lReq), .lWe(lWe), .lAddr(lAddr), .lUserRegion(lUserRegion),
    .strobe(strobe),
    .iReady(iReady), .xReady(xReady), .yReady(yReady),
    .lReady(lReady), .lErr(lErr)
  );

  xyMemArbDatapath #(.AW(AW), .NPAGE(NPAGE), .DW(DW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .iReady(iReady), .xReady(xReady), .yReady(yReady), .lReady(lReady),
    .iAddr(iAddr), .iWdata(iWdata),
    .xAddr(xAddr), .xWdata(xWdata),
    .yAddr(yAddr), .yWdata(yWdata),
    .lAddr(lAddr), .lWdata(lWdata),
    .iRdata(iRdata), .xRdata(xRdata), .yRdata(yRdata), .lRdata(lRdata)
  );
endmodule

// File: rtl/xyMemArbChk.sv
module xyMemArbChk #(
  parameter int AW    = 6,
  parameter int NPAGE = 2
) (
  input logic        clk,
  input logic        rstN,
  input logic        iReq,
  input logic [AW:0] iAddr,
  input logic        iReady,
  input logic        xReq,
  input logic [AW-1:0] xAddr,
  input logic        xReady,
  input logic        yReq,
  input logic [AW-1:0] yAddr,
  input logic        yReady,
  input logic        lReq,
  input logic [AW:0] lAddr,
  input logic        lReady,
  input logic        lErr
);
  localparam int PB = $clog2(NPAGE);

  logic iOnXPage, iOnYPage, xOnLPage, yOnLPage;
  assign iOnXPage = iReq && !iAddr[AW] && (iAddr[AW-1 -: PB] == xAddr[AW-1 -: PB]);
  assign iOnYPage = iReq &&  iAddr[AW] && (iAddr[AW-1 -: PB] == yAddr[AW-1 -: PB]);
  assign xOnLPage = xReq && !lAddr[AW] && (lAddr[AW-1 -: PB] == xAddr[AW-1 -: PB]);
  assign yOnLPage = yReq &&  lAddr[AW] && (lAddr[AW-1 -: PB] == yAddr[AW-1 -: PB]);

  assert_sys_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    iReq |-> iReady);

  assert_x_beats_local_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lReq && xOnLPage) |-> !lReady);

  assert_y_beats_local_R3: assert property (@(posedge clk) disable iff (!rstN)
    (lReq && yOnLPage) |-> !lReady);

  assert_x_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    (xReq && !iOnXPage) |-> xReady);

  assert_y_free_R4: assert property (@(posedge clk) disable iff (!rstN)
    (yReq && !iOnYPage) |-> yReady);

  assert_loser_waits_R5: assert property (@(posedge clk) disable iff (!rstN)
    (iOnXPage || !xReq) |-> !xReady);

  assert_refuse_R7: assert property (@(posedge clk) disable iff (!rstN)
    lErr |-> (lReq && !lReady));

  assert_no_ready_in_reset_R9: assert property (@(posedge clk)
    !rstN |-> !(iReady || xReady || yReady || lReady || lErr));
endmodule

bind xyMemArb xyMemArbChk #(.AW(AW), .NPAGE(NPAGE)) u_chk (
  .clk(clk), .rstN(rstN),
  .iReq(iReq), .iAddr(iAddr), .iReady(iReady),
  .xReq(xReq), .xAddr(xAddr), .xReady(xReady),
  .yReq(yReq), .yAddr(yAddr), .yReady(yReady),
  .lReq(lReq), .lAddr(lAddr), .lReady(lReady), .lErr(lErr)
);

// File: tb/xyMemArb_tb.sv
module xyMemArb_tb;
  localparam int AW = 6;
  localparam int NPAGE = 2;
  localparam int DW = 16;
  localparam int WORDS = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modePriv = 0, modeDsp = 0, lUserRegion = 0;
  logic iReq = 0, iWe = 0, xReq = 0, xWe = 0, yReq = 0, yWe = 0, lReq = 0, lWe = 0;
  logic [AW:0] iAddr = '0, lAddr = '0;
  logic [AW-1:0] xAddr = '0, yAddr = '0;
  logic [DW-1:0] iWdata = '0, xWdata = '0, yWdata = '0, lWdata = '0;
  logic iReady, xReady, yReady, lReady, lErr;
  logic [DW-1:0] iRdata, xRdata, yRdata, lRdata;

  logic [DW-1:0] model [2][WORDS];
  int vecs = 0;
  int errs = 0;

  always #4 clk = ~clk;

  xyMemArb #(.AW(AW), .NPAGE(NPAGE), .DW(DW)) u_dut (
    .clk(clk), .rstN(rstN), .modePriv(modePriv), .modeDsp(modeDsp),
    .iReq(iReq), .iWe(iWe), .iAddr(iAddr), .iWdata(iWdata), .iReady(iReady), .iRdata(iRdata),
    .xReq(xReq), .xWe(xWe), .xAddr(xAddr), .xWdata(xWdata), .xReady(xReady), .xRdata(xRdata),
    .yReq(yReq), .yWe(yWe), .yAddr(yAddr), .yWdata(yWdata), .yReady(yReady), .yRdata(yRdata),
    .lReq(lReq), .lWe(lWe), .lAddr(lAddr), .lUserRegion(lUserRegion), .lWdata(lWdata),
    .lReady(lReady), .lErr(lErr), .lRdata(lRdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: inputs already driven after a falling edge
  task automatic runCycle(input string tag);
    logic ok, eI, eX, eY, eL, eE, rdI, rdX, rdY, rdL;
    logic [DW-1:0] dI, dX, dY, dL;
    #1;
    ok = modePriv ? !lUserRegion : (modeDsp && lUserRegion);   // R6
    eI = iReq;                                                   // R1
    eX = xReq && !(iReq && !iAddr[AW] && iAddr[AW-1] == xAddr[AW-1]);
    eY = yReq && !(iReq &&  iAddr[AW] && iAddr[AW-1] == yAddr[AW-1]);
    eL = lReq && ok
       && !(iReq && iAddr[AW:AW-1] == lAddr[AW:AW-1])
       && !(xReq && !lAddr[AW] && xAddr[AW-1] == lAddr[AW-1])
       && !(yReq &&  lAddr[AW] && yAddr[AW-1] == lAddr[AW-1]);
    eE = lReq && !ok;
    chk({tag, " R1 iReady"}, 32'(iReady), 32'(eI));
    chk({tag, " R2 xReady"}, 32'(xReady), 32'(eX));
    chk({tag, " R3 yReady"}, 32'(yReady), 32'(eY));
    chk({tag, " R4 lReady"}, 32'(lReady), 32'(eL));
    chk({tag, " R7 lErr"}, 32'(lErr), 32'(eE));
    rdI = eI && !iWe; dI = model[iAddr[AW]][iAddr[AW-1:0]];
    rdX = eX && !xWe; dX = model[0][xAddr];
    rdY = eY && !yWe; dY = model[1][yAddr];
    rdL = eL && !lWe; dL = model[lAddr[AW]][lAddr[AW-1:0]];
    @(posedge clk);
    if (eI && iWe) model[iAddr[AW]][iAddr[AW-1:0]] = iWdata;
    if (eX && xWe) model[0][xAddr] = xWdata;
    if (eY && yWe) model[1][yAddr] = yWdata;
    if (eL && lWe) model[lAddr[AW]][lAddr[AW-1:0]] = lWdata;
    #1;
    if (rdI) chk({tag, " R8 iRdata"}, 32'(iRdata), 32'(dI));
    if (rdX) chk({tag, " R8 xRdata"}, 32'(xRdata), 32'(dX));
    if (rdY) chk({tag, " R8 yRdata"}, 32'(yRdata), 32'(dY));
    if (rdL) chk({tag, " R8 lRdata"}, 32'(lRdata), 32'(dL));
  endtask

  task automatic idle();
    iReq = 0; xReq = 0; yReq = 0; lReq = 0;
    iWe = 0; xWe = 0; yWe = 0; lWe = 0;
  endtask

  initial begin
    #(8 * 190000);
    errs++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R9: no grants during reset
    @(negedge clk);
    iReq = 1; xReq = 1; lReq = 1;
    #1;
    chk("R9 iReady in reset", 32'(iReady), 0);
    chk("R9 xReady in reset", 32'(xReady), 0);
    chk("R9 lErr in reset", 32'(lErr), 0);
    idle();
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R9 iRdata after reset", 32'(iRdata), 0);
    chk("R9 lRdata after reset", 32'(lRdata), 0);

    // preload both memories via the system bus (R8 write path)
    for (int k = 0; k < 2 * WORDS; k++) begin
      @(negedge clk);
      idle();
      iReq = 1; iWe = 1; iAddr = (AW+1)'(k); iWdata = DW'(k * 37 + 5);
      runCycle("preload");
    end

    // near-exhaustive sweep of requests, targets, pages and modes
    for (int c = 0; c < 8192; c++) begin
      @(negedge clk);
      iReq = c[0]; xReq = c[1]; yReq = c[2]; lReq = c[3];
      iAddr = {c[4], c[6], 5'($urandom)};
      lAddr = {c[5], c[9], 5'($urandom)};
      xAddr = {c[7], 5'($urandom)};
      yAddr = {c[8], 5'($urandom)};
      modePriv = c[10]; modeDsp = c[11]; lUserRegion = c[12];
      iWe = 1'($urandom); xWe = 1'($urandom); yWe = 1'($urandom); lWe = 1'($urandom);
      iWdata = DW'($urandom); xWdata = DW'($urandom);
      yWdata = DW'($urandom); lWdata = DW'($urandom);
      runCycle("sweep");
    end

    // R5: local read stalls while the system bus holds X page 0
    modePriv = 1; modeDsp = 0; lUserRegion = 0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      idle();
      iReq = 1; iWe = 0; iAddr = 7'h03;
      lReq = 1; lWe = 0; lAddr = 7'h09;
      runCycle("R5 stall");
    end
    @(negedge clk);
    iReq = 0;
    runCycle("R5 release");

    // R7: refused local write leaves memory untouched
    @(negedge clk);
    idle();
    modePriv = 0; modeDsp = 0; lUserRegion = 1;
    lReq = 1; lWe = 1; lAddr = 7'h45; lWdata = 16'hDEAD;
    runCycle("R7 refused write");
    @(negedge clk);
    idle();
    iReq = 1; iWe = 0; iAddr = 7'h45;
    runCycle("R7 readback");

    // R4/R6: X and Y DSP plus user-DSP local on a free page, all in one cycle
    @(negedge clk);
    idle();
    modePriv = 0; modeDsp = 1; lUserRegion = 1;
    xReq = 1; xAddr = 6'h01; yReq = 1; yAddr = 6'h22;
    lReq = 1; lWe = 1; lAddr = 7'h30; lWdata = 16'h1234;
    runCycle("R4 parallel");
    @(negedge clk);
    idle();
    xReq = 1; xWe = 0; xAddr = 6'h30;
    runCycle("R8 readback");

    @(negedge clk);
    idle();
    @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule